// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter fed by a programmable prescaler. It is steered by one control/status register. In interval mode an overflow of the counter raises a level interrupt request that stays high until software clears the overflow flag. In watchdog mode an overflow sends out a single-clock request. A control bit routes that request either to the chip reset generator or to the non-maskable interrupt line.

Software reaches two locations over a simple strobed register bus: the control/status register and the counter. A write carries a 16-bit word. The upper byte is a key and the lower byte is the data, so a stray write with the wrong key changes nothing. The overflow flag clears only through an acknowledge sequence: a read that sees the flag set, followed by a write of zero to that bit. A standby input drops the run-related controls and keeps the prescaler selection.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x10, the counter (address 1) reads 0x00, and intervalIrq, resetReq and nmiReq are low.
- R2: The control/status register layout is: bit 7 overflow flag, bit 6 mode (0 interval, 1 watchdog), bit 5 enable, bit 4 reserved, bit 3 request select (0 reset, 1 NMI), bits 2..0 clock select. Bit 4 always reads 1 and written values have no effect on it.
- R3: A control write takes effect only when regWrData[15:8] is 0xA5. A counter write takes effect only when regWrData[15:8] is 0x5A. Any other key leaves the target unchanged.
- R4: While enable is 0 the counter reads 0x00 and does not advance, and counter writes have no effect.
- R5: With enable at 1 and clock select code s, the counter advances by exactly one every 2^(s+1) clocks.
- R6: When the counter steps from 0xFF to 0x00 the overflow flag becomes 1.
- R7: A control write with bit 7 at 0 clears the flag only if a control read has seen the flag at 1 since the flag was last set. A write without such a read leaves the flag set. Writing 1 to bit 7 never sets it.
- R8: If an overflow occurs between the arming read and the clearing write, the flag stays set after that write.
- R9: In interval mode, intervalIrq equals the overflow flag, and resetReq and nmiReq stay low.
- R10: In watchdog mode each overflow produces a pulse of exactly one clock on resetReq (select 0) or on nmiReq (select 1), never on both. intervalIrq stays low.
- R11: A standby cycle clears the flag, mode, enable and request select bits, keeps the clock select bits, and returns the counter to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby-mode indication |
| regAddr | input | 1 | 0 selects control/status, 1 selects counter |
| regRd | input | 1 | Read strobe, one cycle per access |
| regWr | input | 1 | Write strobe, one cycle per access |
| regWrData | input | 16 | Key in [15:8], data in [7:0] |
| regRdData | output | 8 | Read data for the addressed location |
| intervalIrq | output | 1 | Interval-mode interrupt request (level) |
| resetReq | output | 1 | Watchdog reset request (one-clock pulse) |
| nmiReq | output | 1 | Watchdog NMI request (one-clock pulse) |

## Verification
The embedded properties assume single-cycle read and write strobes that never fall in the same cycle, and a standby input that does not coincide with a register write. The single-clock request pulse also depends on the prescaler never ticking on two consecutive clocks, which holds because the smallest ratio is two. The stimulus issues every access through tasks that raise one strobe for exactly one clock. It holds standby for a single isolated cycle with the bus idle, and it forces overflows by loading 0xFF into the counter at the fastest ratio.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int DATA_W = 8;
  parameter int KEY_W = 8;
  parameter int SEL_W = 3;
  localparam int PRE_W = 1 << SEL_W;
  localparam int BUS_W = KEY_W + DATA_W;
  localparam logic [KEY_W-1:0] KEY_CTRL = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_CNT = 8'h5A;

  // control/status bit positions
  localparam int FLAG_BIT = 7;
  localparam int MODE_BIT = 6;
  localparam int EN_BIT = 5;
  localparam int RSV_BIT = 4;
  localparam int SEL_BIT = 3;

  typedef struct packed {
    logic run;
    logic load;
    logic [DATA_W-1:0] loadVal;
    logic [SEL_W-1:0] clkSel;
  } dpStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  dpStrobes_t strb,
  output logic [DATA_W-1:0] count,
  output logic ovfPulse
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] tickVec;
  logic tick;

  // one tick candidate per divide ratio: low g+1 bits of the prescaler all ones
  genvar g;
  generate
    for (g = 0; g < PRE_W; g++) begin : gTick
      assign tickVec[g] = &pre[g:0];
    end
  endgenerate

  assign tick = tickVec[strb.clkSel];

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (!strb.run) pre <= '0;
    else pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (!strb.run) count <= '0;
    else if (strb.load) count <= strb.loadVal;
    else if (tick) count <= count + 1'b1;
  end

  assign ovfPulse = strb.run && !strb.load && tick && (count == {DATA_W{1'b1}});

  // R4
  run_off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> count == '0);

  // R5
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load && tick) |=> count == DATA_W'($past(count) + 1'b1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic standby,
  input  logic regAddr,
  input  logic regRd,
  input  logic regWr,
  input  logic [BUS_W-1:0] regWrData,
  input  logic [DATA_W-1:0] count,
  input  logic ovfPulse,
  output dpStrobes_t strb,
  output logic [DATA_W-1:0] regRdData,
  output logic intervalIrq,
  output logic resetReq,
  output logic nmiReq
);
  logic flag, mode, enable, reqSel, armed;
  logic [SEL_W-1:0] clkSel;
  logic [KEY_W-1:0] wKey;
  logic [DATA_W-1:0] wByte;
  logic ctrlWr, cntWr, ctrlRd;

  assign wKey = regWrData[BUS_W-1:DATA_W];
  assign wByte = regWrData[DATA_W-1:0];
  assign ctrlWr = regWr && !regAddr && (wKey == KEY_CTRL);
  assign cntWr = regWr && regAddr && (wKey == KEY_CNT);
  assign ctrlRd = regRd && !regAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
      mode <= 1'b0;
      enable <= 1'b0;
      reqSel <= 1'b0;
      armed <= 1'b0;
      clkSel <= '0;
    end else begin
      if (ctrlWr) clkSel <= wByte[SEL_W-1:0];
      if (standby) begin
        flag <= 1'b0;
        mode <= 1'b0;
        enable <= 1'b0;
        reqSel <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (ctrlWr) begin
          mode <= wByte[MODE_BIT];
          enable <= wByte[EN_BIT];
          reqSel <= wByte[SEL_BIT];
        end
        if (ovfPulse) begin
          flag <= 1'b1;
          armed <= 1'b0;
        end else if (ctrlWr && !wByte[FLAG_BIT] && armed) begin
          flag <= 1'b0;
          armed <= 1'b0;
        end else if (ctrlRd && flag) begin
          armed <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      resetReq <= 1'b0;
      nmiReq <= 1'b0;
    end else begin
      resetReq <= ovfPulse && mode && !reqSel;
      nmiReq <= ovfPulse && mode && reqSel;
    end
  end

  assign intervalIrq = flag && !mode;

  always_comb begin
    strb.run = enable && !standby;
    strb.load = cntWr;
    strb.loadVal = wByte;
    strb.clkSel = clkSel;
  end

  always_comb begin
    if (regAddr) regRdData = count;
    else regRdData = {flag, mode, enable, 1'b1, reqSel, clkSel};
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> flag);

  // R7
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flag) && !$past(standby)) |-> $past(ctrlWr && !wByte[FLAG_BIT]));

  // R10
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R10
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> !nmiReq);

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && nmiReq));

  // R11
  standby_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!enable && !flag && !mode && !reqSel));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic standby,
  input  logic regAddr,
  input  logic regRd,
  input  logic regWr,
  input  logic [BUS_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic intervalIrq,
  output logic resetReq,
  output logic nmiReq
);
  dpStrobes_t strb;
  logic [DATA_W-1:0] count;
  logic ovfPulse;

  wdt_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .standby(standby),
    .regAddr(regAddr),
    .regRd(regRd),
    .regWr(regWr),
    .regWrData(regWrData),
    .count(count),
    .ovfPulse(ovfPulse),
    .strb(strb),
    .regRdData(regRdData),
    .intervalIrq(intervalIrq),
    .resetReq(resetReq),
    .nmiReq(nmiReq)
  );

  wdt_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .count(count),
    .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0;
  logic regAddr = 1'b0;
  logic regRd = 1'b0;
  logic regWr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [7:0] regRdData;
  logic intervalIrq, resetReq, nmiReq;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] expVal;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_timer u_dut (
    .clk(clk), .rstN(rstN), .standby(standby),
    .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData),
    .intervalIrq(intervalIrq), .resetReq(resetReq), .nmiReq(nmiReq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each checked read against the queued expectation
  always @(negedge clk) begin
    expItem_t it;
    #1;
    if (regRd) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: actual=%h expected=queued item", regRdData);
      end else begin
        it = expQ.pop_front();
        check(regRdData, it.expVal, it.tag);
      end
    end
  end

  task automatic readChk(input logic a, input logic [7:0] e, input string tag);
    expQ.push_back('{e, tag});
    regAddr = a;
    regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic rawRead(input logic a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] key, input logic [7:0] data);
    regAddr = a;
    regWrData = {key, data};
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic watchReqs(input int n, output int rc, output int nc, output int ic);
    rc = 0; nc = 0; ic = 0;
    repeat (n) begin
      @(negedge clk);
      rc += int'(resetReq);
      nc += int'(nmiReq);
      ic += int'(intervalIrq);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v0;
    int rc, nc, ic;
    repeat (3) @(negedge clk);
    check({5'b0, intervalIrq, resetReq, nmiReq}, 8'h00, "R1 pins in reset");
    rstN = 1'b1;
    @(negedge clk);
    readChk(1'b0, 8'h10, "R1 ctrl");
    readChk(1'b1, 8'h00, "R1 count");

    // wrong control key ignored
    wr(1'b0, 8'h00, 8'h27);
    readChk(1'b0, 8'h10, "R3 bad ctrl key");
    // reserved bit stays 1
    wr(1'b0, 8'hA5, 8'h07);
    readChk(1'b0, 8'h17, "R2 reserved bit");
    // writing 1 to the flag never sets it
    wr(1'b0, 8'hA5, 8'hFF);
    readChk(1'b0, 8'h7F, "R7 write one");
    wr(1'b0, 8'hA5, 8'h00);
    readChk(1'b0, 8'h10, "R2 cleared");

    // disabled counter
    wr(1'b1, 8'h5A, 8'h40);
    readChk(1'b1, 8'h00, "R4 load while off");
    repeat (20) @(negedge clk);
    readChk(1'b1, 8'h00, "R4 held");

    // counter key check at slowest ratio
    wr(1'b0, 8'hA5, 8'h27);
    wr(1'b1, 8'h5A, 8'h10);
    wr(1'b1, 8'hA5, 8'h80);
    readChk(1'b1, 8'h10, "R3 bad count key");

    // divide ratios
    for (int i = 0; i < 3; i++) begin
      int sel;
      int ratio;
      sel = (i == 0) ? 0 : (i == 1) ? 2 : 5;
      ratio = 1 << (sel + 1);
      wr(1'b0, 8'hA5, 8'h20 | 8'(sel));
      wr(1'b1, 8'h5A, 8'h00);
      rawRead(1'b1, v0);
      repeat (4*ratio - 1) @(negedge clk);
      readChk(1'b1, v0 + 8'd4, "R5 ratio");
    end

    // interval-mode overflow
    wr(1'b0, 8'hA5, 8'h20);
    wr(1'b1, 8'h5A, 8'hFF);
    watchReqs(6, rc, nc, ic);
    check(8'(rc + nc), 8'd0, "R9 no watchdog request");
    check({7'b0, intervalIrq}, 8'd1, "R9 irq follows flag");
    wr(1'b0, 8'hA5, 8'h20);
    readChk(1'b0, 8'hB0, "R7 write without read; R6 flag");
    wr(1'b0, 8'hA5, 8'h20);
    readChk(1'b0, 8'h30, "R7 cleared after read");
    check({7'b0, intervalIrq}, 8'd0, "R9 irq low after clear");

    // overflow between arming read and clearing write
    wr(1'b1, 8'h5A, 8'hFF);
    watchReqs(6, rc, nc, ic);
    readChk(1'b0, 8'hB0, "R8 flag set");
    wr(1'b1, 8'h5A, 8'hFF);
    watchReqs(6, rc, nc, ic);
    wr(1'b0, 8'hA5, 8'h20);
    readChk(1'b0, 8'hB0, "R8 flag kept");
    wr(1'b0, 8'hA5, 8'h20);
    readChk(1'b0, 8'h30, "R7 cleared");

    // watchdog mode, reset request
    wr(1'b0, 8'hA5, 8'h60);
    wr(1'b1, 8'h5A, 8'hFF);
    watchReqs(6, rc, nc, ic);
    check(8'(rc), 8'd1, "R10 reset pulse count");
    check(8'(nc), 8'd0, "R10 no nmi");
    check(8'(ic), 8'd0, "R10 no interval irq");
    readChk(1'b0, 8'hF0, "R10 flag in watchdog");
    wr(1'b0, 8'hA5, 8'h68);
    readChk(1'b0, 8'h78, "R10 select nmi");
    wr(1'b1, 8'h5A, 8'hFF);
    watchReqs(6, rc, nc, ic);
    check(8'(nc), 8'd1, "R10 nmi pulse count");
    check(8'(rc), 8'd0, "R10 no reset");

    // standby
    wr(1'b0, 8'hA5, 8'h7D);
    readChk(1'b0, 8'hFD, "R11 before standby");
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    readChk(1'b0, 8'h15, "R11 ctrl after standby");
    readChk(1'b1, 8'h00, "R11 count after standby");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule